// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This controller refills one cache line after a miss. It takes a miss request made of a line address and the offset of the word that missed. It then issues a single burst request to memory. The request carries the offset at which the memory must begin and whether the burst wraps around the end of the line. Memory returns the eight words of the line one per accepted beat. The controller steers each beat into the line array. In the same cycle as the missed word arrives, it hands that word to the processor, so the processor can resume while the rest of the line is still filling.

Two orderings are selectable per miss. In wrapped mode the burst starts at the missed word and wraps, so the processor is released on the first beat. In early-restart mode the burst starts at word 0, and the missed word is forwarded when its beat passes. During a fill the processor may read other words of the same line. A word that has already been written is returned at once. A word that has not yet arrived is reported as not ready, so the processor stalls on it. The line is marked valid only after every word is in the array.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset `busy`, `mem_req_valid`, `arr_we`, `crit_valid` and `arr_valid_set` are all 0.
- R2: A miss accepted while idle produces, in the next cycle only, `mem_req_valid`=1 with `mem_req_line` equal to the miss line and `mem_req_wrap` equal to `wrap_mode`. `mem_req_word` is the missed offset when `wrap_mode`=1 and 0 when `wrap_mode`=0.
- R3: With `wrap_mode`=1, response beat k (counted from 0) is written to word (offset + k) mod 8. The missed word is therefore fetched before any other word.
- R4: With `wrap_mode`=0, response beat k is written to word k.
- R5: `crit_valid` is 1 in exactly the cycle in which the beat carrying the missed word is written, with `crit_data` equal to that beat's data. It pulses once per fill and never after the line is complete.
- R6: `busy` is 1 from the cycle after a miss is accepted until the cycle after `arr_valid_set`. A `miss_valid` seen while busy starts no request and does not change the line being filled.
- R7: `arr_valid_set` is a one-cycle pulse, with `arr_line` equal to the miss line, in the cycle after the eighth word is written. It never occurs before that.
- R8: `acc_ready`=1 and `acc_data` equal to the stored word when `acc_valid`=1 and word `acc_word` was written in an earlier cycle of the current or last fill. Otherwise `acc_ready`=0, which means the processor must stall.
- R9: `rsp_valid` outside the beat-accepting phase of a fill, including while idle, causes no `arr_we` and no `crit_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | OFF_W | Offset of the missed word |
| wrap_mode | input | 1 | 1 = wrapped critical-word-first, 0 = sequential early restart |
| busy | output | 1 | Fill in progress, new misses held off |
| mem_req_valid | output | 1 | Burst request to memory (one cycle) |
| mem_req_line | output | LINE_W | Burst line address |
| mem_req_word | output | OFF_W | First word of the burst |
| mem_req_wrap | output | 1 | Burst wraps at the line end |
| rsp_valid | input | 1 | Memory returns one word |
| rsp_data | input | DATA_W | Returned word |
| crit_valid | output | 1 | Missed word handed to the processor |
| crit_data | output | DATA_W | Missed word |
| acc_valid | input | 1 | Processor reads a word of the filling line |
| acc_word | input | OFF_W | Word offset read |
| acc_ready | output | 1 | Read word is available |
| acc_data | output | DATA_W | Read word data |
| arr_we | output | 1 | Line-array word write |
| arr_line | output | LINE_W | Line-array row |
| arr_word | output | OFF_W | Line-array word within the row |
| arr_wdata | output | DATA_W | Line-array write data |
| arr_valid_set | output | 1 | Set the valid bit of `arr_line` |

## Verification
The checks assume that memory sends exactly eight beats per burst and only after the request cycle. They also assume that `acc_valid` refers to the line most recently requested. The bench keeps to this: it raises `rsp_valid` only once the request cycle has passed, it stops after the eighth beat, and it issues stray responses only while the controller is idle. Misses raised during a fill are dropped again before the controller returns to idle, so each one is tested only for being ignored.

// File: rtl/cwf_pkg.sv
// Shared types for the critical-word-first line fill controller.
// Assumes nothing beyond a standard SystemVerilog flow.
package cwf_pkg;

    // Phase of one line fill
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a miss
        ST_REQ  = 2'd1,   // burst request on the memory port
        ST_FILL = 2'd2,   // accepting response beats
        ST_DONE = 2'd3    // line complete, valid bit set
    } fill_state_t;

endpackage

// File: rtl/cwf_wrap_seq.sv
// Word order generator: maps the beat index of a burst to a word offset.
// Wrapped mode starts at the missed word and wraps modulo the line size;
// sequential mode starts at word 0. Assumes WORDS is a power of two.
module cwf_wrap_seq #(
    parameter int WORDS = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic [OFF_W-1:0] req_word,
    input  logic             wrap,
    input  logic [OFF_W-1:0] beat,
    output logic [OFF_W-1:0] start_word,
    output logic [OFF_W-1:0] cur_word
);

    // Starting offset and current offset; modulo arithmetic is the natural wrap of OFF_W bits
    always_comb begin
        start_word = wrap ? req_word : '0;
        cur_word   = start_word + beat;
    end

endmodule

// File: rtl/cwf_fill_track.sv
// Fill tracker: holds the words of the line being filled and a written mask,
// and serves processor reads of already-written words. Assumes at most one
// write per cycle and that clear is raised when a new fill begins.
module cwf_fill_track #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    input  logic [OFF_W-1:0]  word,
    input  logic [DATA_W-1:0] wdata,
    input  logic              acc_valid,
    input  logic [OFF_W-1:0]  acc_word,
    output logic              acc_ready,
    output logic [DATA_W-1:0] acc_data,
    output logic [WORDS-1:0]  written
);

    logic [DATA_W-1:0] store [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // Written flag for word i: cleared at the start of a fill, set on its write
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                written[i] <= 1'b0;
            else if (we && word == OFF_W'(i))
                written[i] <= 1'b1;
        end

        // Data holder for word i
        always_ff @(posedge clk) begin
            if (we && word == OFF_W'(i))
                store[i] <= wdata;
        end
    end

    // Read port: ready only for a word written in an earlier cycle
    always_comb begin
        acc_ready = acc_valid && written[acc_word];
        acc_data  = store[acc_word];
    end

endmodule

// File: rtl/cwf_fill_ctrl.sv
// Fill sequencer: accepts a miss while idle, issues one burst request,
// counts WORDS response beats, flags the missed word and closes the fill.
// Assumes memory sends exactly WORDS beats, none before the request cycle.
module cwf_fill_ctrl
    import cwf_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int LINE_W = 26,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [OFF_W-1:0]  miss_word,
    input  logic              wrap_mode,
    input  logic              rsp_valid,
    input  logic [OFF_W-1:0]  cur_word,
    output logic              busy,
    output logic              req_pulse,
    output logic              take,
    output logic              crit,
    output logic              commit,
    output logic              clear,
    output logic [LINE_W-1:0] req_line,
    output logic [OFF_W-1:0]  req_word,
    output logic              wrap_q,
    output logic [OFF_W-1:0]  beat
);

    fill_state_t state;
    logic        crit_seen;

    // Phase register, captured miss and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            req_line  <= '0;
            req_word  <= '0;
            wrap_q    <= 1'b0;
            beat      <= '0;
            crit_seen <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (miss_valid) begin
                    state     <= ST_REQ;
                    req_line  <= miss_line;
                    req_word  <= miss_word;
                    wrap_q    <= wrap_mode;
                    beat      <= '0;
                    crit_seen <= 1'b0;
                end
                ST_REQ:  state <= ST_FILL;
                ST_FILL: if (rsp_valid) begin
                    beat <= beat + 1'b1;
                    if (crit)
                        crit_seen <= 1'b1;
                    if (beat == OFF_W'(WORDS - 1))
                        state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decoded strobes for the datapath
    always_comb begin
        busy      = (state != ST_IDLE);
        req_pulse = (state == ST_REQ);
        take      = (state == ST_FILL) && rsp_valid;
        crit      = take && (cur_word == req_word);
        commit    = (state == ST_DONE);
        clear     = (state == ST_IDLE) && miss_valid;
    end

    // R5: the missed word is handed over only once per fill
    a_r5_crit_once: assert property (@(posedge clk) disable iff (!rst_n)
        crit |-> !crit_seen);

    // R2: the burst request lasts one cycle and the controller stays busy after it
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_pulse |=> (!req_pulse && busy));

endmodule

// File: rtl/cwf_line_fill.sv
// Critical-word-first line fill controller (top). Joins the sequencer, the
// word order generator and the fill tracker; drives the memory request, the
// line-array write port and the processor return ports.
// Assumes memory returns beats in the order it was asked for.
module cwf_line_fill
    import cwf_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    parameter int LINE_W = 26,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [OFF_W-1:0]  miss_word,
    input  logic              wrap_mode,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [LINE_W-1:0] mem_req_line,
    output logic [OFF_W-1:0]  mem_req_word,
    output logic              mem_req_wrap,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              crit_valid,
    output logic [DATA_W-1:0] crit_data,
    input  logic              acc_valid,
    input  logic [OFF_W-1:0]  acc_word,
    output logic              acc_ready,
    output logic [DATA_W-1:0] acc_data,
    output logic              arr_we,
    output logic [LINE_W-1:0] arr_line,
    output logic [OFF_W-1:0]  arr_word,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_valid_set
);

    logic              take, crit, commit, clear, req_pulse, wrap_q;
    logic [LINE_W-1:0] req_line;
    logic [OFF_W-1:0]  req_word, beat, start_word, cur_word;
    logic [WORDS-1:0]  written;

    cwf_fill_ctrl #(.WORDS(WORDS), .LINE_W(LINE_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .miss_line  (miss_line),
        .miss_word  (miss_word),
        .wrap_mode  (wrap_mode),
        .rsp_valid  (rsp_valid),
        .cur_word   (cur_word),
        .busy       (busy),
        .req_pulse  (req_pulse),
        .take       (take),
        .crit       (crit),
        .commit     (commit),
        .clear      (clear),
        .req_line   (req_line),
        .req_word   (req_word),
        .wrap_q     (wrap_q),
        .beat       (beat)
    );

    cwf_wrap_seq #(.WORDS(WORDS)) i_seq (
        .req_word   (req_word),
        .wrap       (wrap_q),
        .beat       (beat),
        .start_word (start_word),
        .cur_word   (cur_word)
    );

    cwf_fill_track #(.WORDS(WORDS), .DATA_W(DATA_W)) i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .we         (take),
        .word       (cur_word),
        .wdata      (rsp_data),
        .acc_valid  (acc_valid),
        .acc_word   (acc_word),
        .acc_ready  (acc_ready),
        .acc_data   (acc_data),
        .written    (written)
    );

    // Port drive: request, array write, early return of the missed word
    always_comb begin
        mem_req_valid = req_pulse;
        mem_req_line  = req_line;
        mem_req_word  = start_word;
        mem_req_wrap  = wrap_q;
        arr_we        = take;
        arr_line      = req_line;
        arr_word      = cur_word;
        arr_wdata     = rsp_data;
        crit_valid    = crit;
        crit_data     = rsp_data;
        arr_valid_set = commit;
    end

    // R3: in wrapped mode the first beat lands on the missed word
    a_r3_wrap_head: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && wrap_q && beat == '0) |-> (arr_word == req_word));

    // R4: in sequential mode beat k lands on word k
    a_r4_seq_order: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !wrap_q) |-> (arr_word == beat));

    // R7: the valid bit is set only once every word has been written
    a_r7_valid_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid_set |-> (&written));

    // R9: no array write happens while idle
    a_r9_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

endmodule

// File: tb/test_cwf_line_fill.sv
// Self-checking bench: a vector table of fills walked by one loop, then
// directed tests for reset, stray responses and misses held off while busy.
module test_cwf_line_fill;

    localparam int WORDS  = 8;
    localparam int DATA_W = 32;
    localparam int LINE_W = 26;
    localparam int OFF_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              miss_valid, wrap_mode, rsp_valid, acc_valid;
    logic [LINE_W-1:0] miss_line;
    logic [OFF_W-1:0]  miss_word, acc_word;
    logic [DATA_W-1:0] rsp_data;
    logic              busy, mem_req_valid, mem_req_wrap, crit_valid, acc_ready;
    logic              arr_we, arr_valid_set;
    logic [LINE_W-1:0] mem_req_line, arr_line;
    logic [OFF_W-1:0]  mem_req_word, arr_word;
    logic [DATA_W-1:0] crit_data, acc_data, arr_wdata;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    cwf_line_fill #(.WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W)) i_cwf_line_fill (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
        .miss_word(miss_word), .wrap_mode(wrap_mode), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
        .mem_req_word(mem_req_word), .mem_req_wrap(mem_req_wrap),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .crit_valid(crit_valid),
        .crit_data(crit_data), .acc_valid(acc_valid), .acc_word(acc_word),
        .acc_ready(acc_ready), .acc_data(acc_data), .arr_we(arr_we),
        .arr_line(arr_line), .arr_word(arr_word), .arr_wdata(arr_wdata),
        .arr_valid_set(arr_valid_set)
    );

    // Vector: {intrude, gap[3:0], wrap, word[2:0], line[15:0]}; gap 8 = no pause
    localparam int NV = 6;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 4'd8, 1'b1, 3'd5, 16'h1234},
        {1'b0, 4'd3, 1'b1, 3'd0, 16'h0042},
        {1'b1, 4'd2, 1'b1, 3'd7, 16'hBEEF},
        {1'b0, 4'd8, 1'b0, 3'd6, 16'h0F0F},
        {1'b0, 4'd4, 1'b0, 3'd2, 16'h7A00},
        {1'b1, 4'd1, 1'b0, 3'd0, 16'h5555}
    };

    function automatic logic [DATA_W-1:0] mk(input logic [15:0] ln, input int b);
        return {ln, 8'(b), 8'h3C};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One complete fill with per-beat checks
    task automatic run_fill(input logic [15:0] ln, input int wd, input bit wr,
                            input int gap, input bit intrude);
        logic [LINE_W-1:0] lx;
        lx = LINE_W'(ln);
        @(negedge clk);
        miss_valid = 1'b1; miss_line = lx; miss_word = OFF_W'(wd); wrap_mode = wr;
        @(negedge clk);
        miss_valid = 1'b0;
        #1;
        chk(mem_req_valid && busy && mem_req_line == lx && mem_req_wrap == wr,
            "R2 request", {mem_req_valid, busy, mem_req_wrap}, 3'b111);
        chk(mem_req_word == OFF_W'(wr ? wd : 0), "R2 start word",
            mem_req_word, wr ? wd : 0);
        @(negedge clk);
        for (int b = 0; b < WORDS; b++) begin
            int ew;
            ew = wr ? ((wd + b) % WORDS) : b;
            if (intrude && b == 0) begin
                miss_valid = 1'b1; miss_line = ~lx; miss_word = 3'd1;
            end
            if (b == gap) begin
                rsp_valid = 1'b0;
                acc_valid = 1'b1;
                acc_word = OFF_W'(wr ? wd : 0);
                #1;
                chk(acc_ready && acc_data == mk(ln, 0), "R8 written word served",
                    {acc_ready, acc_data}, {1'b1, mk(ln, 0)});
                acc_word = OFF_W'(ew);
                #1;
                chk(!acc_ready, "R8 unwritten word stalls", acc_ready, 0);
                chk(!arr_we && !crit_valid, "R9 no write without response",
                    {arr_we, crit_valid}, 0);
                acc_valid = 1'b0;
                @(negedge clk);
            end
            rsp_valid = 1'b1;
            rsp_data = mk(ln, b);
            #1;
            chk(arr_we && arr_word == OFF_W'(ew) && arr_wdata == mk(ln, b) && arr_line == lx,
                wr ? "R3 wrapped beat" : "R4 sequential beat", arr_word, ew);
            chk(crit_valid == (ew == wd) && (ew != wd || crit_data == mk(ln, b)),
                "R5 missed word forward", {crit_valid, crit_data}, {ew == wd, mk(ln, b)});
            chk(!arr_valid_set && !mem_req_valid && busy, "R6/R7 mid-fill",
                {arr_valid_set, mem_req_valid, busy}, 3'b001);
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        miss_valid = 1'b0;
        #1;
        chk(arr_valid_set && arr_line == lx && busy && !crit_valid,
            "R7 valid set after last word", {arr_valid_set, arr_line}, {1'b1, lx});
        @(negedge clk);
        #1;
        chk(!busy && !arr_valid_set && !mem_req_valid, "R6 idle after fill",
            {busy, arr_valid_set, mem_req_valid}, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; miss_valid = 1'b0; wrap_mode = 1'b0; rsp_valid = 1'b0;
        acc_valid = 1'b0; miss_line = '0; miss_word = '0; acc_word = '0; rsp_data = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(!busy && !mem_req_valid && !arr_we && !crit_valid && !arr_valid_set,
            "R1 reset outputs", {busy, mem_req_valid, arr_we, crit_valid, arr_valid_set}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Stray response while idle (R9)
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = 32'hDEAD_BEEF;
        #1;
        chk(!arr_we && !crit_valid && !busy, "R9 idle response ignored",
            {arr_we, crit_valid, busy}, 0);
        @(negedge clk);
        rsp_valid = 1'b0;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            run_fill(VEC[v][15:0], int'(VEC[v][18:16]), VEC[v][19],
                     int'(VEC[v][23:20]), VEC[v][24]);
        end

        // R8 after completion: every word of the last line is served
        @(negedge clk);
        acc_valid = 1'b1;
        for (int w = 0; w < WORDS; w++) begin
            acc_word = OFF_W'(w);
            #1;
            chk(acc_ready && acc_data == mk(16'h5555, w), "R8 complete line read",
                acc_data, mk(16'h5555, w));
        end
        acc_valid = 1'b0;
        #1;
        chk(!acc_ready, "R8 no access no ready", acc_ready, 0);

        // R5 at the last beat of a sequential fill
        run_fill(16'h0ACE, 7, 1'b0, 8, 1'b0);

        // R1 again: reset mid-fill returns to idle
        @(negedge clk);
        miss_valid = 1'b1; miss_line = 26'h3; miss_word = 3'd2; wrap_mode = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(!busy && !mem_req_valid && !arr_valid_set, "R1 reset during fill",
            {busy, mem_req_valid, arr_valid_set}, 0);
        rst_n = 1'b1;
        run_fill(16'h0003, 2, 1'b1, 8, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule